// File: doc/BRIEF.md
# Interrupt Register Bank Save Sequencer

This block preserves a processor's banked working set (R0 to R14, PR, GBR, MACH, MACL: nineteen 32-bit words) across interrupt entry, and brings it back when the restore-from-bank instruction runs. Every accepted interrupt pushes the status word and then the program counter to the memory stack. If banking is enabled for that interrupt and an on-chip bank is free, the whole set is copied into the bank selected by the bank number in the strobe cycle, and the bank number then steps up. When all fifteen banks are full, a control bit decides the outcome. With the bit clear, the set is spilled to the stack and the overflow flag is raised. With the bit set, an overflow exception is signalled and the stack is not touched.

A restore strobe with the overflow flag set pops the set back from the stack. With the flag clear, it reloads the set from the most recent bank and steps the bank number down. Restored words leave the block one per cycle on a register-file write port. The stack port moves one 32-bit word per cycle: each push first lowers the stack pointer by 4, and each pop reads at the pointer and then raises it by 4. The CPU pipeline, the interrupt priority logic and the real memory are outside the block.

The controller is one state machine with these states: IDLE, PUSH_SR, PUSH_PC, SPILL, POP, BANK_LD, DONE. It has these transitions:
- IDLE to PUSH_SR on an accepted interrupt, except in the overflow case.
- IDLE to DONE on the overflow case, or on a restore with no bank in use and the flag clear.
- IDLE to POP on a restore with the flag set.
- IDLE to BANK_LD on a restore with a bank in use and the flag clear.
- PUSH_SR to PUSH_PC.
- PUSH_PC to SPILL when spilling, otherwise to DONE.
- SPILL, POP and BANK_LD to DONE after their last word.
- DONE to IDLE.

Top module: `irq_bank_seq`

## Requirements
- R1: An interrupt with banking enabled and bank number below 15 stores the input set into the bank at the current bank number, adds one to the bank number, and pushes SR then PC.
- R2: An interrupt with banking enabled, bank number 15 and the control bit 0 writes 21 words at descending addresses, each 4 below the previous, starting at stack pointer minus 4. The order is SR, PC, MACL, MACH, GBR, PR, R14 down to R0. The bank number stays 15.
- R3: After a stack spill the overflow flag reads 1.
- R4: An interrupt with banking enabled, bank number 15 and the control bit 1 performs no memory write, pulses the overflow exception output together with done, and leaves the overflow flag and the bank number unchanged.
- R5: A restore with the overflow flag at 1 reads 19 words upward from the supplied stack pointer. It writes them to register indices 0 to 18, where 0-14 are R0-R14, 15 is PR, 16 is GBR, 17 is MACH and 18 is MACL. The final pointer is the start value plus 76, and the bank number stays 15.
- R6: A restore with the flag at 0 and bank number n>0 sets the bank number to n-1 and writes the 19 words of bank n-1 to indices 0 to 18 in order, with no memory access.
- R7: A restore with the flag at 0 and bank number 0 writes no register and only pulses done.
- R8: An interrupt with banking disabled pushes only SR and PC and leaves the bank number unchanged.
- R9: Busy runs from the cycle after a strobe through the done cycle: 3 cycles for a plain entry, 22 for a spill, 20 for a restore that moves words, and 1 when no word moves. Done lasts one cycle, and strobes seen while busy are ignored.
- R10: An interrupt strobe and a restore strobe in the same idle cycle start the interrupt, and the restore is dropped.
- R11: Reset clears the bank number, the overflow flag, the control bit and busy.
- R12: A write to the control bit stores the written value, and the control-bit output shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_take | input | 1 | Interrupt accepted strobe |
| irq_bank_en | input | 1 | Banking enabled for this interrupt |
| rest_req | input | 1 | Restore-from-bank strobe |
| xcfg_we | input | 1 | Control bit write enable |
| xcfg_val | input | 1 | Control bit write value |
| sr_val | input | DW | Status word to push |
| pc_val | input | DW | Program counter to push |
| sp_val | input | AW | Stack pointer at strobe |
| regs_in | input | NREG*DW | Banked set, word i at bits i*DW |
| mem_en | output | 1 | Stack access valid |
| mem_we | output | 1 | Stack write (1) or read (0) |
| mem_addr | output | AW | Stack byte address |
| mem_wdata | output | DW | Stack write data |
| mem_rdata | input | DW | Stack read data, same cycle |
| rf_we | output | 1 | Register restore write |
| rf_idx | output | IDXW | Register index restored |
| rf_wdata | output | DW | Register restore data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final cycle of a sequence |
| ovf_exc | output | 1 | Bank overflow exception pulse |
| bank_num | output | BNW | Bank number |
| ovf_flag | output | 1 | Overflow flag |
| xcfg | output | 1 | Overflow-exception control bit |
| sp_out | output | AW | Current stack pointer |

## Verification
Two pairs of strobes can meet in one cycle: an interrupt strobe with a restore strobe, and either strobe with a sequence that is still running. The bench raises both strobes in one idle cycle while the overflow flag is set, so a pop would be visible. It then checks that only the SR and PC writes appear and that no register write follows. It also raises both strobes during the second cycle of a plain entry and checks that the busy length, the bank number and the scoreboard stream are unchanged, and that busy falls after done.

// File: rtl/irqbk_pkg.sv
package irqbk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_SPILL,
        ST_POP,
        ST_BANK_LD,
        ST_DONE
    } seq_st_e;

    typedef enum logic [1:0] {
        OP_ENTRY,
        OP_SPILL,
        OP_OVF,
        OP_RESTORE
    } seq_op_e;

    localparam int STACK_STEP = 4;
endpackage

// File: rtl/irqbk_bank_store.sv
module irqbk_bank_store #(
    parameter int DW    = 32,
    parameter int NBANK = 15,
    parameter int NREG  = 19,
    localparam int SELW = $clog2(NBANK + 1),
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [SELW-1:0]      wr_sel,
    input  logic [NREG*DW-1:0]   wr_data,
    input  logic [SELW-1:0]      rd_sel,
    input  logic [IDXW-1:0]      rd_idx,
    output logic [DW-1:0]        rd_data
);
    logic [DW-1:0] store_q [NBANK][NREG];

    // whole set written in one cycle
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int w = 0; w < NREG; w++) begin
                store_q[wr_sel][w] <= wr_data[w*DW +: DW];
            end
            // R1: only a free bank may be written
            p_bank_sel_r1: assert (wr_sel < SELW'(NBANK))
                else $error("bank write to full selector");
        end
    end

    assign rd_data = (rd_sel < SELW'(NBANK)) ? store_q[rd_sel][rd_idx] : '0;
endmodule

// File: rtl/irqbk_stack_agu.sv
module irqbk_stack_agu #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] push_addr
);
    logic [AW-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     sp_q <= '0;
        else if (load)  sp_q <= load_val;
        else if (push)  sp_q <= sp_q - AW'(STEP);
        else if (pop)   sp_q <= sp_q + AW'(STEP);
    end

    assign sp        = sp_q;
    assign push_addr = sp_q - AW'(STEP);

    // R2/R5: the pointer moves one way per cycle
    p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
    p_load_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !(push || pop));
endmodule

// File: rtl/irq_bank_seq.sv
module irq_bank_seq
    import irqbk_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int NBANK = 15,
    parameter int NREG  = 19,
    localparam int BNW  = $clog2(NBANK + 1),
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_take,
    input  logic                irq_bank_en,
    input  logic                rest_req,
    input  logic                xcfg_we,
    input  logic                xcfg_val,
    input  logic [DW-1:0]       sr_val,
    input  logic [DW-1:0]       pc_val,
    input  logic [AW-1:0]       sp_val,
    input  logic [NREG*DW-1:0]  regs_in,
    output logic                mem_en,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata,
    output logic                rf_we,
    output logic [IDXW-1:0]     rf_idx,
    output logic [DW-1:0]       rf_wdata,
    output logic                busy,
    output logic                done,
    output logic                ovf_exc,
    output logic [BNW-1:0]      bank_num,
    output logic                ovf_flag,
    output logic                xcfg,
    output logic [AW-1:0]       sp_out
);
    localparam logic [BNW-1:0]  BN_FULL  = BNW'(NBANK);
    localparam logic [IDXW-1:0] IDX_LAST = IDXW'(NREG - 1);

    seq_st_e         state_q, state_d;
    seq_op_e         op_q;
    logic [IDXW-1:0] cnt_q;
    logic [BNW-1:0]  bn_q;
    logic            bo_q, xcfg_q;
    logic [DW-1:0]   sr_q, pc_q;
    logic [DW-1:0]   snap_q [NREG];

    logic idle, accept_irq, accept_rest, full_hit, save_ok;
    logic agu_load, agu_push, agu_pop;
    logic [AW-1:0] sp_cur, sp_push_addr;
    logic [DW-1:0] bank_word;

    assign idle        = (state_q == ST_IDLE);
    assign accept_irq  = idle && irq_take;
    assign accept_rest = idle && rest_req && !irq_take;
    assign full_hit    = irq_bank_en && (bn_q == BN_FULL);
    assign save_ok     = irq_bank_en && (bn_q != BN_FULL);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (irq_take) begin
                    state_d = (full_hit && xcfg_q) ? ST_DONE : ST_PUSH_SR;
                end else if (rest_req) begin
                    if (bo_q)              state_d = ST_POP;
                    else if (bn_q != '0)   state_d = ST_BANK_LD;
                    else                   state_d = ST_DONE;
                end
            end
            ST_PUSH_SR: state_d = ST_PUSH_PC;
            ST_PUSH_PC: state_d = (op_q == OP_SPILL) ? ST_SPILL : ST_DONE;
            ST_SPILL:   if (cnt_q == '0)      state_d = ST_DONE;
            ST_POP:     if (cnt_q == IDX_LAST) state_d = ST_DONE;
            ST_BANK_LD: if (cnt_q == IDX_LAST) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---------------- sequencing data ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_ENTRY;
            cnt_q  <= '0;
            bn_q   <= '0;
            bo_q   <= 1'b0;
            xcfg_q <= 1'b0;
            sr_q   <= '0;
            pc_q   <= '0;
        end else begin
            if (xcfg_we) xcfg_q <= xcfg_val;
            if (accept_irq) begin
                sr_q  <= sr_val;
                pc_q  <= pc_val;
                cnt_q <= IDX_LAST;
                if (full_hit && xcfg_q) op_q <= OP_OVF;
                else if (full_hit)      op_q <= OP_SPILL;
                else                    op_q <= OP_ENTRY;
                if (save_ok) bn_q <= bn_q + 1'b1;
            end else if (accept_rest) begin
                op_q  <= OP_RESTORE;
                cnt_q <= '0;
                if (!bo_q && bn_q != '0) bn_q <= bn_q - 1'b1;
            end else begin
                unique case (state_q)
                    ST_SPILL: begin
                        cnt_q <= cnt_q - 1'b1;
                        if (cnt_q == '0) bo_q <= 1'b1;
                    end
                    ST_POP, ST_BANK_LD: cnt_q <= cnt_q + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // snapshot of the set, read word by word during a spill
    always_ff @(posedge clk) begin
        if (accept_irq) begin
            for (int w = 0; w < NREG; w++) snap_q[w] <= regs_in[w*DW +: DW];
        end
    end

    // ---------------- submodules ----------------
    assign agu_load = accept_irq || accept_rest;
    assign agu_push = (state_q == ST_PUSH_SR) || (state_q == ST_PUSH_PC) ||
                      (state_q == ST_SPILL);
    assign agu_pop  = (state_q == ST_POP);

    irqbk_stack_agu #(.AW(AW), .STEP(STACK_STEP)) u_agu (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (agu_load),
        .load_val  (sp_val),
        .push      (agu_push),
        .pop       (agu_pop),
        .sp        (sp_cur),
        .push_addr (sp_push_addr)
    );

    irqbk_bank_store #(.DW(DW), .NBANK(NBANK), .NREG(NREG)) u_banks (
        .clk     (clk),
        .wr_en   (accept_irq && save_ok),
        .wr_sel  (bn_q),
        .wr_data (regs_in),
        .rd_sel  (bn_q),
        .rd_idx  (cnt_q),
        .rd_data (bank_word)
    );

    // ---------------- outputs ----------------
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sp_push_addr;
        mem_wdata = '0;
        rf_we     = 1'b0;
        rf_wdata  = '0;
        unique case (state_q)
            ST_PUSH_SR: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = sr_q; end
            ST_PUSH_PC: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = pc_q; end
            ST_SPILL:   begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = snap_q[cnt_q]; end
            ST_POP: begin
                mem_en   = 1'b1;
                mem_addr = sp_cur;
                rf_we    = 1'b1;
                rf_wdata = mem_rdata;
            end
            ST_BANK_LD: begin rf_we = 1'b1; rf_wdata = bank_word; end
            default: ;
        endcase
    end

    assign rf_idx   = cnt_q;
    assign busy     = !idle;
    assign done     = (state_q == ST_DONE);
    assign ovf_exc  = done && (op_q == OP_OVF);
    assign bank_num = bn_q;
    assign ovf_flag = bo_q;
    assign xcfg     = xcfg_q;
    assign sp_out   = sp_cur;

    // ---------------- assertions ----------------
    p_bn_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bank_num <= BN_FULL);
    p_spill_bn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPILL || state_q == ST_POP) |-> bank_num == BN_FULL);
    p_flag_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(state_q) == ST_SPILL);
    p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |-> ($past(!mem_en) && $stable(ovf_flag)));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_en || rf_we));
endmodule

// File: tb/sim_irq_bank_seq.sv
module sim_irq_bank_seq;
    localparam int DW = 32, AW = 32, NB = 15, NR = 19;
    localparam logic [31:0] SP0 = 32'h0000_0800;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, irq_take, irq_bank_en, rest_req, xcfg_we, xcfg_val;
    logic [DW-1:0] sr_val, pc_val, mem_wdata, mem_rdata, rf_wdata;
    logic [AW-1:0] sp_val, mem_addr, sp_out;
    logic [NR*DW-1:0] regs_in;
    logic mem_en, mem_we, rf_we, busy, done, ovf_exc, ovf_flag, xcfg;
    logic [4:0] rf_idx;
    logic [3:0] bank_num;

    irq_bank_seq u0 (.*);

    logic [31:0] mem [1024];
    always @(posedge clk) if (mem_en && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[11:2]];

    typedef struct { logic rf; logic [31:0] a; logic [31:0] d; string req; } item_t;
    item_t exp_q[$];
    int checks = 0, fails = 0;

    logic [31:0] bank_m [NB][NR];
    logic [31:0] smodel [logic [31:0]];
    int bn_m = 0, tag = 0;
    logic bo_m = 0, ctl_m = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void expect_item(input logic rf, input logic [31:0] a, input logic [31:0] d, input string req);
        item_t it;
        it.rf = rf; it.a = a; it.d = d; it.req = req;
        exp_q.push_back(it);
    endfunction

    // monitor: pops the scoreboard as the design produces results
    task automatic take_item(input logic rf, input logic [31:0] a, input logic [31:0] d);
        item_t it;
        if (exp_q.size() == 0) begin
            check(1'b0, rf ? "R9 unexpected register write" : "R4/R9 unexpected memory write", a, 32'hx);
        end else begin
            it = exp_q.pop_front();
            check(it.rf == rf && it.a == a, {it.req, " address/index"}, a, it.a);
            check(it.d == d, {it.req, " data"}, d, it.d);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_en && mem_we) take_item(1'b0, mem_addr, mem_wdata);
            if (rf_we) take_item(1'b1, 32'(rf_idx), rf_wdata);
        end
    end

    function automatic logic [31:0] word_of(input int t, input int i);
        return 32'hA000_0000 | (t << 8) | i;
    endfunction

    task automatic run_op(input logic tk, input logic rs, input logic ben, input logic poke,
                          output int cyc, output logic exc);
        @(negedge clk);
        irq_take = tk; rest_req = rs; irq_bank_en = ben;
        @(negedge clk);
        irq_take = 0; rest_req = 0;
        cyc = 1;
        while (!done && cyc < 100) begin
            if (poke && cyc == 1) begin irq_take = 1; rest_req = 1; irq_bank_en = 1; end
            @(negedge clk);
            irq_take = 0; rest_req = 0;
            cyc++;
        end
        exc = ovf_exc;
        @(negedge clk);
    endtask

    task automatic do_irq(input logic ben, input logic poke, input string req);
        int cyc, ecyc; logic exc, eexc; logic [31:0] sp;
        tag++;
        for (int i = 0; i < NR; i++) regs_in[i*32 +: 32] = word_of(tag, i);
        sr_val = 32'h5000_0000 | tag;
        pc_val = 32'h0000_1000 + tag * 16;
        sp_val = SP0;
        eexc = 0; ecyc = 3; sp = SP0;
        if (ben && bn_m == NB && ctl_m) begin
            eexc = 1; ecyc = 1;
        end else begin
            sp -= 4; expect_item(0, sp, sr_val, req); smodel[sp] = sr_val;
            sp -= 4; expect_item(0, sp, pc_val, req); smodel[sp] = pc_val;
            if (ben && bn_m < NB) begin
                for (int i = 0; i < NR; i++) bank_m[bn_m][i] = word_of(tag, i);
                bn_m++;
            end else if (ben) begin
                for (int i = NR - 1; i >= 0; i--) begin
                    sp -= 4; expect_item(0, sp, word_of(tag, i), "R2 spill");
                    smodel[sp] = word_of(tag, i);
                end
                bo_m = 1; ecyc = 22;
            end
        end
        run_op(1, 0, ben, poke, cyc, exc);
        check(cyc == ecyc, {req, " busy length"}, cyc, ecyc);
        check(exc == eexc, {req, " exception pulse"}, exc, eexc);
        check(bank_num == bn_m, {req, " bank number"}, bank_num, bn_m);
        check(ovf_flag == bo_m, "R3 overflow flag", ovf_flag, bo_m);
        check(sp_out == sp, {req, " stack pointer"}, sp_out, sp);
        check(!busy && exp_q.size() == 0, {req, " R9 idle and drained"}, exp_q.size(), 0);
    endtask

    task automatic do_restore(input logic [31:0] sp0, input string req);
        int cyc, ecyc; logic exc;
        sp_val = sp0; ecyc = 1;
        if (bo_m) begin
            for (int i = 0; i < NR; i++) expect_item(1, i, smodel[sp0 + 4*i], req);
            ecyc = 20;
        end else if (bn_m > 0) begin
            bn_m--;
            for (int i = 0; i < NR; i++) expect_item(1, i, bank_m[bn_m][i], req);
            ecyc = 20;
        end
        run_op(0, 1, 0, 0, cyc, exc);
        check(cyc == ecyc, {req, " busy length"}, cyc, ecyc);
        check(bank_num == bn_m, {req, " bank number"}, bank_num, bn_m);
        if (bo_m) check(sp_out == sp0 + 76, "R5 final pointer", sp_out, sp0 + 76);
        check(exp_q.size() == 0, {req, " drained"}, exp_q.size(), 0);
    endtask

    task automatic write_ctl(input logic v);
        @(negedge clk); xcfg_we = 1; xcfg_val = v;
        @(negedge clk); xcfg_we = 0;
        ctl_m = v;
        check(xcfg == v, "R12 control bit", xcfg, v);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        bn_m = 0; bo_m = 0; ctl_m = 0; exp_q.delete();
        @(negedge clk);
        check(bank_num == 0, "R11 bank number", bank_num, 0);
        check(ovf_flag == 0, "R11 overflow flag", ovf_flag, 0);
        check(xcfg == 0, "R11 control bit", xcfg, 0);
        check(busy == 0, "R11 busy", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc; logic exc;
        irq_take = 0; irq_bank_en = 0; rest_req = 0; xcfg_we = 0; xcfg_val = 0;
        sr_val = 0; pc_val = 0; sp_val = SP0; regs_in = '0;
        do_reset();
        write_ctl(1);
        write_ctl(0);
        do_irq(0, 0, "R8 plain entry");
        for (int k = 0; k < NB; k++) do_irq(1, 0, "R1 bank save");
        do_restore(SP0, "R6 bank reload");
        do_irq(1, 0, "R1 bank refill");
        do_irq(1, 0, "R2 spill entry");
        do_irq(0, 1, "R9 strobes while busy");
        do_restore(SP0 - 84, "R5 stack restore");
        // R10: both strobes in one idle cycle, interrupt wins
        tag++;
        sr_val = 32'h5000_0000 | tag; pc_val = 32'h0000_1000 + tag * 16; sp_val = SP0;
        expect_item(0, SP0 - 4, sr_val, "R10 simultaneous");
        expect_item(0, SP0 - 8, pc_val, "R10 simultaneous");
        run_op(1, 1, 0, 0, cyc, exc);
        check(cyc == 3, "R10 busy length", cyc, 3);
        check(exp_q.size() == 0 && !busy, "R10 restore dropped", exp_q.size(), 0);
        write_ctl(1);
        do_irq(1, 0, "R4 overflow");
        do_reset();
        do_restore(SP0, "R7 empty restore");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule